// File: doc/BRIEF.md
# Bit-Serial Priority Switch Element

A 2x2 switching cell for a crossbar that routes cells one bit per clock. A serial stream enters from the west and another from the north. Two strobes mark which bits of the current cell belong to the address field and which to the priority field. A start-of-cell pulse, aligned with the first bit of each cell, returns the cell to its default cross routing. In cross routing the west stream leaves east and the north stream leaves south. In toggle routing the west stream leaves south and the north stream leaves east.

While the bits stream through, the cell compares the two addresses. If they agree over the whole address field, it then runs an MSB-first race on the priority bits. The race ends at the first differing bit, and a smaller priority value wins. Toggle routing is taken only when the west cell wins the race. The routing takes effect on the bit that reveals the decision and is held until the next start-of-cell pulse. Data and strobes are registered, so every bit reaches the east and south neighbours one clock after it arrives. The address field may be a single multicast bitmap bit or a multi-bit unicast group number. Its length is set only by the address strobe.

Top module: `swe_cell`

## Requirements
- R1: A start-of-cell pulse (cell_init_i high together with the first bit of a cell) clears any routing held from the previous cell, so the cell starts in cross routing.
- R2: Toggle routing is taken only when every address bit of the two streams agrees and the west cell has the higher priority.
- R3: The priority comparison ends at the first bit position where the two streams differ. Priority bits after that position do not change the routing.
- R4: A smaller priority value is a higher priority. At the first differing priority bit, west=0 and north=1 gives toggle, and west=1 and north=0 keeps cross.
- R5: Any address bit mismatch keeps cross routing for the rest of the cell, whatever the priorities are.
- R6: The address field length is set only by the address strobe. A 1-bit field (multicast) and a multi-bit field (unicast) are both handled.
- R7: Data bits and both field strobes leave the cell exactly one clock after they arrive. After reset all outputs are 0.
- R8: The east and south copies of each field strobe are equal in every cycle.
- R9: The routing changes on the very bit that reveals the decision. Earlier bits of the cell pass in cross routing, and all later bits, including the payload, use the decided routing until the next start-of-cell pulse.
- R10: Equal addresses and equal priorities leave the cell in cross routing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cell_init_i | input | 1 | Start-of-cell pulse, high with the first bit of a cell |
| west_bit_i | input | 1 | Serial stream from the west |
| north_bit_i | input | 1 | Serial stream from the north |
| addr_fld_i | input | 1 | High while the current bit belongs to the address field |
| prio_fld_i | input | 1 | High while the current bit belongs to the priority field |
| east_bit_o | output | 1 | Serial stream to the east neighbour |
| south_bit_o | output | 1 | Serial stream to the south neighbour |
| east_addr_fld_o | output | 1 | Address strobe forwarded east |
| south_addr_fld_o | output | 1 | Address strobe forwarded south |
| east_prio_fld_o | output | 1 | Priority strobe forwarded east |
| south_prio_fld_o | output | 1 | Priority strobe forwarded south |

## Verification
The hardest case to reach is a routing decision made part-way through a cell and then held across the remaining priority and payload bits. The held routing must then be cleared by the next start-of-cell pulse, while the next cell's first bits are already arriving. The stimulus sends cells back to back, with no idle bit between them. Their priorities first differ at chosen positions, and later bits point the other way, so that any re-evaluation after the decision shows up at the outputs. One cell toggles and is followed directly by a cell whose address mismatches only on its last address bit. This exercises both the clearing and the full-field address match.

// File: rtl/swe_pkg.sv
package swe_pkg;
  typedef enum logic {
    ROUTE_CROSS  = 1'b0,
    ROUTE_TOGGLE = 1'b1
  } route_e;

  localparam int unsigned STAGE_W = 5;  // init, west, north, addr strobe, prio strobe
endpackage

// File: rtl/swe_stage.sv
module swe_stage #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d_i;
  end

  assert_stage_delay_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> q_o == $past(d_i));
endmodule

// File: rtl/swe_decide.sv
module swe_decide
  import swe_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   init_i,
  input  logic   west_i,
  input  logic   north_i,
  input  logic   addr_fld_i,
  input  logic   prio_fld_i,
  output route_e route_o
);
  logic   decided_q;
  route_e held_q;
  logic   held_vld, differ, decide_now;
  route_e route_d;

  assign held_vld = decided_q & ~init_i;
  assign differ   = west_i ^ north_i;

  always_comb begin
    decide_now = 1'b0;
    route_d    = ROUTE_CROSS;
    if (held_vld) begin
      route_d = held_q;
    end else if (addr_fld_i && differ) begin
      decide_now = 1'b1;  // address mismatch: cross for the cell
    end else if (prio_fld_i && differ) begin
      decide_now = 1'b1;
      route_d    = west_i ? ROUTE_CROSS : ROUTE_TOGGLE;
    end
  end

  assign route_o = route_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      decided_q <= 1'b0;
      held_q    <= ROUTE_CROSS;
    end else if (decide_now) begin
      decided_q <= 1'b1;
      held_q    <= route_d;
    end else if (init_i) begin
      decided_q <= 1'b0;
      held_q    <= ROUTE_CROSS;
    end
  end

  assert_mismatch_cross_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_fld_i && differ) |-> route_o == ROUTE_CROSS);
  assert_toggle_source_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (route_o == ROUTE_TOGGLE) |-> ((prio_fld_i && !west_i && north_i) || held_vld));
  assert_decision_held_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (decided_q && !init_i) |=> $stable(held_q));
  assert_init_clears_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (init_i && !prio_fld_i) |-> route_o == ROUTE_CROSS);
  assert_equal_bits_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!held_vld && !differ) |-> route_o == ROUTE_CROSS);
endmodule

// File: rtl/swe_xbar.sv
module swe_xbar
  import swe_pkg::*;
#(
  parameter int unsigned W = 1
) (
  input  route_e       route_i,
  input  logic [W-1:0] west_i,
  input  logic [W-1:0] north_i,
  output logic [W-1:0] east_o,
  output logic [W-1:0] south_o
);
  always_comb begin
    if (route_i == ROUTE_TOGGLE) begin
      east_o  = north_i;
      south_o = west_i;
    end else begin
      east_o  = west_i;
      south_o = north_i;
    end
  end

  always_comb begin
    assert_xbar_perm_R2: assert ($countones({east_o, south_o}) == $countones({west_i, north_i}));
  end
endmodule

// File: rtl/swe_cell.sv
module swe_cell
  import swe_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cell_init_i,
  input  logic west_bit_i,
  input  logic north_bit_i,
  input  logic addr_fld_i,
  input  logic prio_fld_i,
  output logic east_bit_o,
  output logic south_bit_o,
  output logic east_addr_fld_o,
  output logic south_addr_fld_o,
  output logic east_prio_fld_o,
  output logic south_prio_fld_o
);
  logic [STAGE_W-1:0] stage_d, stage_q;
  logic   init_q, west_q, north_q, addr_q, prio_q;
  route_e route;

  assign stage_d = {cell_init_i, west_bit_i, north_bit_i, addr_fld_i, prio_fld_i};
  assign {init_q, west_q, north_q, addr_q, prio_q} = stage_q;

  swe_stage #(.W(STAGE_W)) u_stage (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (stage_d),
    .q_o    (stage_q)
  );

  swe_decide u_decide (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .init_i     (init_q),
    .west_i     (west_q),
    .north_i    (north_q),
    .addr_fld_i (addr_q),
    .prio_fld_i (prio_q),
    .route_o    (route)
  );

  swe_xbar #(.W(1)) u_xbar (
    .route_i (route),
    .west_i  (west_q),
    .north_i (north_q),
    .east_o  (east_bit_o),
    .south_o (south_bit_o)
  );

  // one strobe register feeds both neighbours
  assign east_addr_fld_o  = addr_q;
  assign south_addr_fld_o = addr_q;
  assign east_prio_fld_o  = prio_q;
  assign south_prio_fld_o = prio_q;

  assert_strobe_fwd_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (east_addr_fld_o == $past(addr_fld_i)) && (south_prio_fld_o == $past(prio_fld_i)));
  assert_data_fwd_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ({east_bit_o, south_bit_o} == {$past(west_bit_i), $past(north_bit_i)}) ||
             ({east_bit_o, south_bit_o} == {$past(north_bit_i), $past(west_bit_i)}));
endmodule

// File: tb/swe_cell_tb_top.sv
`timescale 1ns/1ps
module swe_cell_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic init, wb, nb, af, pf;
  logic eb, sb, eaf, saf, epf, spf;
  int   checks = 0;
  int   errors = 0;
  bit   done = 0;

  localparam int PW  = 4;
  localparam int PAY = 6;

  always #5 clk = ~clk;

  swe_cell dut_i (
    .clk_i            (clk),
    .rst_ni           (rst_n),
    .cell_init_i      (init),
    .west_bit_i       (wb),
    .north_bit_i      (nb),
    .addr_fld_i       (af),
    .prio_fld_i       (pf),
    .east_bit_o       (eb),
    .south_bit_o      (sb),
    .east_addr_fld_o  (eaf),
    .south_addr_fld_o (saf),
    .east_prio_fld_o  (epf),
    .south_prio_fld_o (spf)
  );

  task automatic chk(string req, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  // Sends one cell: aw address bits, PW priority bits, PAY payload bits, MSB first.
  task automatic send_cell(string req, int aw, int wa, int na, int wp, int np, int wpay, int npay);
    int len = aw + PW + PAY;
    int dec_idx = -1;
    logic tog = 1'b0;
    logic [31:0] ws, ns;
    ws = (wa << (PW + PAY)) | (wp << PAY) | wpay;
    ns = (na << (PW + PAY)) | (np << PAY) | npay;
    for (int j = 0; j < aw; j++)
      if (dec_idx < 0 && ws[len-1-j] != ns[len-1-j]) dec_idx = j;
    if (dec_idx < 0)
      for (int j = aw; j < aw + PW; j++)
        if (dec_idx < 0 && ws[len-1-j] != ns[len-1-j]) begin
          dec_idx = j;
          tog = ~ws[len-1-j];
        end
    for (int i = 0; i < len; i++) begin
      logic t, ea, pa;
      @(negedge clk);
      init = (i == 0);
      wb = ws[len-1-i];
      nb = ns[len-1-i];
      af = (i < aw);
      pf = (i >= aw) && (i < aw + PW);
      ea = af;
      pa = pf;
      @(posedge clk);
      #1;
      t = (dec_idx >= 0 && i >= dec_idx) ? tog : 1'b0;
      chk(req, eb, t ? ns[len-1-i] : ws[len-1-i], $sformatf("east bit %0d", i));
      chk(req, sb, t ? ws[len-1-i] : ns[len-1-i], $sformatf("south bit %0d", i));
      chk("R7", eaf, ea, $sformatf("addr strobe bit %0d", i));
      chk("R7", epf, pa, $sformatf("prio strobe bit %0d", i));
      chk("R8", saf, eaf, "south addr strobe copy");
      chk("R8", spf, epf, "south prio strobe copy");
    end
  endtask

  task automatic test_reset();
    chk("R7", eb, 1'b0, "reset east");
    chk("R7", sb, 1'b0, "reset south");
    chk("R7", eaf | saf | epf | spf, 1'b0, "reset strobes");
  endtask

  task automatic test_unicast_toggle();  // R2 R4 R9: prio 3 beats 5
    send_cell("R2", 3, 5, 5, 4'b0011, 4'b0101, 6'b101100, 6'b010011);
  endtask

  task automatic test_unicast_cross_prio();  // R4: west 6 loses to north 2
    send_cell("R4", 3, 5, 5, 4'b0110, 4'b0010, 6'b111000, 6'b000111);
  endtask

  task automatic test_addr_mismatch();  // R5: west has better prio but addr differs
    send_cell("R5", 3, 5, 4, 4'b0000, 4'b1111, 6'b110011, 6'b001100);
  endtask

  task automatic test_late_mismatch_after_toggle();  // R1 R5: toggle cell then mismatch on last addr bit
    send_cell("R9", 3, 6, 6, 4'b0001, 4'b1000, 6'b011010, 6'b100101);
    send_cell("R1", 3, 6, 7, 4'b0000, 4'b1111, 6'b010101, 6'b101010);
  endtask

  task automatic test_stop_first_diff();  // R3: first diff at MSB, later bits oppose
    send_cell("R3", 3, 2, 2, 4'b0111, 4'b1000, 6'b001011, 6'b110100);
    send_cell("R3", 3, 2, 2, 4'b1000, 4'b0111, 6'b001011, 6'b110100);
  endtask

  task automatic test_equal();  // R10
    send_cell("R10", 3, 1, 1, 4'b0101, 4'b0101, 6'b100110, 6'b011001);
  endtask

  task automatic test_multicast();  // R6 R1: 1-bit address field
    send_cell("R6", 1, 1, 1, 4'b0010, 4'b0100, 6'b110101, 6'b001010);
    send_cell("R6", 1, 1, 0, 4'b0000, 4'b1111, 6'b110101, 6'b001010);
    send_cell("R6", 1, 0, 0, 4'b1110, 4'b1111, 6'b000111, 6'b111000);
  endtask

  initial begin
    init = 0; wb = 0; nb = 0; af = 0; pf = 0;
    repeat (3) @(posedge clk);
    #1;
    test_reset();
    @(negedge clk);
    rst_n = 1'b1;
    test_unicast_toggle();
    test_unicast_cross_prio();
    test_addr_mismatch();
    test_late_mismatch_after_toggle();
    test_stop_first_diff();
    test_equal();
    test_multicast();
    @(negedge clk);
    init = 0; wb = 0; nb = 0; af = 0; pf = 0;
    @(posedge clk);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule